// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the display-memory word address that an LCD refresh engine reads from. A frame-start pulse reloads it, a line-start pulse marks each new panel line, and each fetch strobe consumes the current word and advances to the next one. The panel can be split horizontally. Lines at the top are read from a first base address. After a programmable number of lines, every remaining line of the frame is read from a second base address.

A signed-free pitch offset is added when each line ends. The memory image can therefore be wider than the panel, and the panel shows a window into it. Moving the two base addresses pans that window across the stored image. In dual-panel mode the programmed split line is ignored: the second base address always feeds the lower half of the panel. The pitch offset works the same way in both modes.

The refresh engine supplies the panel height and the number of words per line at run time. It reads the address and a screen-select flag directly from the outputs.

Top module: `split_addr_gen`

## Requirements
- R1: A frame-start pulse loads the first base address into the fetch address and drives the screen-select output to 0 (0 = upper screen, 1 = lower screen) on the next clock edge; frame start has priority over line start and fetch.
- R2: A fetch strobe that is accepted advances the fetch address by exactly one word on the next edge, and the 16-bit address wraps from 0xFFFF to 0x0000.
- R3: Within one line, only the first `words_per_line` fetch strobes are accepted; further strobes before the next line start leave the address unchanged.
- R4: In single-panel mode, with line-count value N, lines 0 to N of the frame (N+1 lines) use the first base address; the line-start pulse of line N+1 loads the second base address, sets screen-select to 1, and every later line of the frame stays on the lower screen.
- R5: On every other line start except the first one after a frame start, the address becomes the last fetched address plus 1 plus the 8-bit unsigned pitch value; the first line start of a frame leaves the freshly loaded address unchanged.
- R6: If the line-count value is greater than or equal to the panel height minus one, the lower screen is never selected in that frame.
- R7: In dual-panel mode the line-count value is ignored, and the switch to the second base address happens at line floor(panel_lines/2).
- R8: The screen-select output changes only on the edge that follows a frame-start or line-start pulse.
- R9: A frame-start pulse in the middle of a frame restarts the line count, so the next frame splits at the programmed line again.
- R10: In cycles with no frame start, line start or fetch, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle pulse at the beginning of a frame |
| line_start | input | 1 | One-cycle pulse at the beginning of each panel line |
| fetch | input | 1 | Strobe: the current address is being read |
| scr1_base | input | 16 | Word address of the upper screen's first line |
| scr2_base | input | 16 | Word address of the lower screen's first line |
| split_line | input | 10 | Upper-screen line count minus one |
| pitch_adj | input | 8 | Extra words skipped between the end of one line and the start of the next |
| words_per_line | input | 8 | Number of fetches accepted per line |
| panel_lines | input | 10 | Panel height in lines |
| dual_panel | input | 1 | 1 selects dual-panel mode |
| fetch_addr | output | 16 | Current display-memory word address |
| scr_sel | output | 1 | 0 while the upper screen is fetched, 1 for the lower |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, a 10-bit line count, an 8-bit pitch and an 8-bit words-per-line field. With these values a full 240-line frame split after line 32 runs in about a thousand cycles, and a base address near 0xFFFE with a nonzero pitch reaches the modulo wrap. The line-count field is wide enough to hold values far beyond the panel height, so the never-split case is reached both just at the limit and well past it. Dual-panel frames with odd and even heights test the half-panel boundary.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // Per-line command from the line controller to the address register.
  typedef struct packed {
    logic load1;  // frame start: take upper base
    logic load2;  // split boundary: take lower base
    logic adv;    // ordinary line step: add pitch
    logic clr;    // any accepted line/frame boundary: clear word count
  } sa_cmd_t;
endpackage

// File: rtl/sa_rst_sync.sv
module sa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sa_line_ctl.sv
module sa_line_ctl
  import sa_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [LINE_W-1:0] split_line,
  input  logic [LINE_W-1:0] panel_lines,
  input  logic              dual_panel,
  output sa_cmd_t           cmd,
  output logic              scr_sel
);
  localparam int BW = LINE_W + 1;
  localparam logic [LINE_W-1:0] IDX_MAX = {LINE_W{1'b1}};

  logic              first_q, first_d;
  logic [LINE_W-1:0] idx_q, idx_d, idx_inc;
  logic              sel_q, sel_d;
  logic [BW-1:0]     bound;
  logic              hit;
  logic              step;
  logic              en;

  // Boundary line index: half panel in dual mode, programmed count + 1 otherwise.
  always_comb begin
    idx_inc = (idx_q == IDX_MAX) ? idx_q : idx_q + 1'b1;
    if (dual_panel) bound = {1'b0, (panel_lines >> 1)};
    else            bound = {1'b0, split_line} + BW'(1);
    hit  = ({1'b0, idx_inc} == bound) && (bound < {1'b0, panel_lines});
    step = !frame_start && line_start && !first_q;
  end

  always_comb begin
    cmd.load1 = frame_start;
    cmd.clr   = frame_start | line_start;
    cmd.load2 = step && hit;
    cmd.adv   = step && !hit;
  end

  always_comb begin
    en      = frame_start | line_start;
    first_d = first_q;
    idx_d   = idx_q;
    sel_d   = sel_q;
    if (frame_start) begin
      first_d = 1'b1;
      idx_d   = '0;
      sel_d   = 1'b0;
    end else if (line_start) begin
      if (first_q) begin
        first_d = 1'b0;
      end else begin
        idx_d = idx_inc;
        if (hit) sel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      idx_q   <= '0;
      sel_q   <= 1'b0;
    end else if (en) begin
      first_q <= first_d;
      idx_q   <= idx_d;
      sel_q   <= sel_d;
    end
  end

  assign scr_sel = sel_q;
endmodule

// File: rtl/sa_addr_reg.sv
module sa_addr_reg
  import sa_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PITCH_W = 8,
  parameter int WPL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sa_cmd_t            cmd,
  input  logic               fetch,
  input  logic [ADDR_W-1:0]  scr1_base,
  input  logic [ADDR_W-1:0]  scr2_base,
  input  logic [PITCH_W-1:0] pitch_adj,
  input  logic [WPL_W-1:0]   words_per_line,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WPL_W-1:0]  wcnt_q, wcnt_d;
  logic              fetch_ok;
  logic              en;

  always_comb begin
    fetch_ok = fetch && (wcnt_q < words_per_line);
    en       = cmd.clr | fetch_ok;
    addr_d   = addr_q;
    wcnt_d   = wcnt_q;
    if (cmd.load1) begin
      addr_d = scr1_base;
      wcnt_d = '0;
    end else if (cmd.load2) begin
      addr_d = scr2_base;
      wcnt_d = '0;
    end else if (cmd.adv) begin
      addr_d = addr_q + ADDR_W'(pitch_adj);
      wcnt_d = '0;
    end else if (cmd.clr) begin
      wcnt_d = '0;
    end else if (fetch_ok) begin
      addr_d = addr_q + 1'b1;
      wcnt_d = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wcnt_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/split_addr_gen.sv
module split_addr_gen
  import sa_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LINE_W  = 10,
  parameter int PITCH_W = 8,
  parameter int WPL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               fetch,
  input  logic [ADDR_W-1:0]  scr1_base,
  input  logic [ADDR_W-1:0]  scr2_base,
  input  logic [LINE_W-1:0]  split_line,
  input  logic [PITCH_W-1:0] pitch_adj,
  input  logic [WPL_W-1:0]   words_per_line,
  input  logic [LINE_W-1:0]  panel_lines,
  input  logic               dual_panel,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               scr_sel
);
  logic    rst_sync_n;
  sa_cmd_t cmd;

  sa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sa_line_ctl #(.LINE_W(LINE_W)) u_line (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .line_start  (line_start),
    .split_line  (split_line),
    .panel_lines (panel_lines),
    .dual_panel  (dual_panel),
    .cmd         (cmd),
    .scr_sel     (scr_sel)
  );

  sa_addr_reg #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (PITCH_W),
    .WPL_W   (WPL_W)
  ) u_addr (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cmd            (cmd),
    .fetch          (fetch),
    .scr1_base      (scr1_base),
    .scr2_base      (scr2_base),
    .pitch_adj      (pitch_adj),
    .words_per_line (words_per_line),
    .addr           (fetch_addr)
  );
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int ADDR_W  = 16,
  parameter int PITCH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               line_start,
  input logic               fetch,
  input logic [ADDR_W-1:0]  scr1_base,
  input logic [ADDR_W-1:0]  scr2_base,
  input logic [PITCH_W-1:0] pitch_adj,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               scr_sel,
  input logic               load2,
  input logic               adv
);
  // R1
  a_r1_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fetch_addr == $past(scr1_base)) && !scr_sel);

  // R4
  a_r4_lower_load: assert property (@(posedge clk) disable iff (!rst_n)
    load2 |=> (fetch_addr == $past(scr2_base)) && scr_sel);

  // R5
  a_r5_pitch_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> fetch_addr == ($past(fetch_addr) + ADDR_W'($past(pitch_adj))));

  // R8
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start) |=> $stable(scr_sel));

  // R10
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start && !fetch) |=> $stable(fetch_addr));
endmodule

bind split_addr_gen sa_checker #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .frame_start (frame_start),
  .line_start  (line_start),
  .fetch       (fetch),
  .scr1_base   (scr1_base),
  .scr2_base   (scr2_base),
  .pitch_adj   (pitch_adj),
  .fetch_addr  (fetch_addr),
  .scr_sel     (scr_sel),
  .load2       (cmd.load2),
  .adv         (cmd.adv)
);

// File: tb/split_addr_gen_tb.sv
`timescale 1ns/1ps
module split_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start, line_start, fetch;
  logic [15:0] scr1_base, scr2_base;
  logic [9:0]  split_line, panel_lines;
  logic [7:0]  pitch_adj, words_per_line;
  logic        dual_panel;
  logic [15:0] fetch_addr;
  logic        scr_sel;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R1";

  typedef struct { logic [15:0] addr; logic sel; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  split_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .fetch(fetch), .scr1_base(scr1_base), .scr2_base(scr2_base),
    .split_line(split_line), .pitch_adj(pitch_adj), .words_per_line(words_per_line),
    .panel_lines(panel_lines), .dual_panel(dual_panel),
    .fetch_addr(fetch_addr), .scr_sel(scr_sel)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Monitor: compare every fetch against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && fetch) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL %s: actual fetch 0x%04h expected none queued", cur_tag, fetch_addr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({cur_tag, " addr"}, fetch_addr, e.addr);
        check({cur_tag, " sel"}, {15'd0, scr_sel}, {15'd0, e.sel});
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Driver: one frame, model computed from the requirements.
  task automatic run_frame(input string tag, input logic [15:0] s1, input logic [15:0] s2,
                           input int split, input int pitch, input int wpl, input int panel,
                           input bit dual, input int nf, input int nl);
    logic [15:0] m;
    logic        sel;
    int          bound;
    cur_tag = tag;
    scr1_base = s1; scr2_base = s2; split_line = split[9:0]; pitch_adj = pitch[7:0];
    words_per_line = wpl[7:0]; panel_lines = panel[9:0]; dual_panel = dual;
    frame_start = 1'b1; tick(); frame_start = 1'b0;
    m = s1; sel = 1'b0;
    bound = dual ? (panel / 2) : (split + 1);
    for (int l = 0; l < nl; l++) begin
      if (l > 0) begin
        if (l == bound && bound < panel) begin m = s2; sel = 1'b1; end
        else m = m + 16'(pitch);
      end
      line_start = 1'b1; tick(); line_start = 1'b0;
      for (int w = 0; w < nf; w++) begin
        exp_t e;
        e.addr = m; e.sel = sel;
        exp_q.push_back(e);
        fetch = 1'b1; tick();
        if (w < wpl) m = m + 16'd1;
      end
      fetch = 1'b0; tick();
    end
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 0; line_start = 0; fetch = 0;
    scr1_base = 0; scr2_base = 0; split_line = 0; pitch_adj = 0;
    words_per_line = 0; panel_lines = 0; dual_panel = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 reset addr", fetch_addr, 16'h0000);
    check("R1 reset sel", {15'd0, scr_sel}, 16'd0);

    // R4: 240-line panel, split value 0x20 -> 33 upper lines
    run_frame("R4", 16'h1000, 16'h8000, 'h20, 0, 2, 240, 0, 2, 240);
    check("R4 end sel", {15'd0, scr_sel}, 16'd1);
    // R5: nonzero pitch (virtual screen) with a split
    run_frame("R5", 16'h0200, 16'h4000, 2, 5, 3, 8, 0, 3, 8);
    // R6: split at panel-1 and far beyond: never lower
    run_frame("R6", 16'h0300, 16'h5000, 5, 1, 2, 6, 0, 2, 6);
    check("R6 sel at limit", {15'd0, scr_sel}, 16'd0);
    run_frame("R6", 16'h0300, 16'h5000, 900, 1, 2, 6, 0, 2, 6);
    check("R6 sel far", {15'd0, scr_sel}, 16'd0);
    // R7: dual panel, split value ignored, even and odd heights
    run_frame("R7", 16'h0400, 16'h6000, 2, 3, 2, 10, 1, 2, 10);
    run_frame("R7", 16'h0400, 16'h6000, 0, 0, 1, 7, 1, 1, 7);
    // R3: over-fetch within a line
    run_frame("R3", 16'h0500, 16'h7000, 1, 2, 2, 4, 0, 4, 4);
    // R2: wrap past 0xFFFF with pitch
    run_frame("R2", 16'hFFFE, 16'h0010, 20, 3, 3, 4, 0, 3, 4);
    // R4 edge: split 0 -> only line 0 upper
    run_frame("R4", 16'h0600, 16'h9000, 0, 0, 1, 3, 0, 1, 3);
    // R9: partial frame then restart
    run_frame("R9", 16'h0700, 16'hA000, 1, 4, 2, 10, 0, 2, 5);
    run_frame("R9", 16'h0800, 16'hB000, 1, 4, 2, 10, 0, 2, 5);
    // R10 / R8: quiet cycles hold address and select
    begin
      logic [15:0] a0;
      logic        s0;
      a0 = fetch_addr; s0 = scr_sel;
      repeat (5) tick();
      check("R10 hold addr", fetch_addr, a0);
      check("R8 hold sel", {15'd0, scr_sel}, {15'd0, s0});
    end
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule